// File: doc/BRIEF.md
# Serial Byte Transmitter with Handshaked Enable

This block sends bytes over a single asynchronous serial line. Software writes a small control word that carries a transmit-enable bit, a parity selection and a stop-bit count. It then writes bytes into a one-deep holding buffer. The transmitter adds a low start bit to each byte and sends the data least significant bit first. An optional parity bit and one or two high stop bits follow. Each bit lasts a fixed number of baud ticks, and the line rests high between frames.

The transmit-enable bit is applied in one of two ways, depending on whether the surrounding peripheral is enabled. If the peripheral is off, the bit takes effect at once. If the peripheral is on, a fixed-length handshake applies the change, and a busy flag stays up until the change has landed. A request to turn the transmitter off is deferred. The line keeps working until the frame on the wire and any byte still in the buffer have both gone out. The readback of the enable bit always shows the state that is actually in force.

Top module: `sertx_core`

## Requirements
- R1: After reset, the line is high, the control readback is zero, the busy flag is low and the buffer-empty flag is high.
- R2: The control readback carries the enable in bit 0, parity-enable in bit 1, odd parity in bit 2 (1 = odd, 0 = even) and two stop bits in bit 3. All other bits read as zero, whatever value was written to them.
- R3: While the peripheral is disabled, a write to the enable bit shows up in the readback on the next cycle, and the busy flag never rises.
- R4: While the peripheral is enabled, writing one to a stopped transmitter raises busy for exactly 3 cycles, during which the enable reads zero. In the next cycle busy is low and the enable reads one.
- R5: A frame is a low start bit followed by 8 data bits, least significant first. Every bit lasts 16 baud ticks, and the line is high whenever no frame is in progress.
- R6: With parity enabled, a parity bit follows the data. It makes the count of ones over the data and parity even (even mode) or odd (odd mode).
- R7: The frame ends with one stop bit, or with two when bit 3 is set. With back-to-back buffered bytes, consecutive start bits lie 16·N+1 cycles apart, where N is the frame length in bits.
- R8: Writing zero to the enable while the transmitter runs keeps busy high and the enable reading one until the current frame and the buffered byte have both been sent. Only then does the enable read zero, and no further frames start.
- R9: A byte write is accepted only while the buffer is empty, and a write to a full buffer is dropped. The empty flag goes low on acceptance and returns high when the frame is loaded.
- R10: While the transmitter is not enabled, no frame starts, and a buffered byte waits until the transmitter is enabled.
- R11: A write to the enable bit while busy is high has no effect on the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_en | input | 1 | Peripheral-level enable; selects immediate or handshaked enable changes |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | REG_W | Control word write data |
| reg_rdata | output | REG_W | Control word readback |
| dat_wr | input | 1 | Byte write strobe |
| dat_in | input | 8 | Byte to send |
| dat_empty | output | 1 | Holding buffer can accept a byte |
| baud_tick | input | 1 | One pulse per sub-bit tick |
| txd | output | 1 | Serial line |
| sync_busy | output | 1 | Enable change pending |
| tx_running | output | 1 | Transmitter enabled and peripheral on |

## Verification
The assertions take it as given that `periph_en` stays steady while a handshake is pending, because a drop in it resolves the pending change at once. They also take it that the baud tick is a clean single-cycle pulse. The bench changes `periph_en` only while busy is low, and it holds the tick high every cycle, so each bit occupies exactly 16 clock cycles. Configuration changes are made only while the line is idle and the buffer is empty.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 4;
    localparam int LW        = $clog2(FRAME_MAX + 1);

    // control word field positions
    localparam int CTL_EN    = 0;
    localparam int CTL_PAR   = 1;
    localparam int CTL_ODD   = 2;
    localparam int CTL_STOP2 = 3;

    typedef struct packed {
        logic two_stop;
        logic par_odd;
        logic par_en;
    } frame_cfg_t;

    typedef enum logic [1:0] {
        SY_IDLE,
        SY_ARM,
        SY_DRAIN
    } sync_state_t;

    // Frame image, bit 0 goes out first; unused upper bits are idle-high.
    function automatic logic [FRAME_MAX-1:0] build_frame(
        input logic [DATA_W-1:0] d,
        input frame_cfg_t        c
    );
        logic [FRAME_MAX-1:0] f;
        f = '1;
        f[0] = 1'b0;
        f[DATA_W:1] = d;
        if (c.par_en) f[DATA_W+1] = (^d) ^ c.par_odd;
        return f;
    endfunction

    function automatic logic [LW-1:0] frame_len(input frame_cfg_t c);
        return LW'(DATA_W + 2) + LW'(c.par_en) + LW'(c.two_stop);
    endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync
    import sertx_pkg::*;
#(
    parameter int SYNC_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic periph_en,
    input  logic wr_req,
    input  logic wr_val,
    input  logic drained,
    output logic run,
    output logic busy
);
    localparam int CW = $clog2(SYNC_CYC + 1);

    sync_state_t   st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SY_IDLE;
            cnt <= '0;
            run <= 1'b0;
        end else if (!periph_en) begin
            st  <= SY_IDLE;
            cnt <= '0;
            if (wr_req)               run <= wr_val;
            else if (st == SY_ARM)    run <= 1'b1;
            else if (st == SY_DRAIN)  run <= 1'b0;
        end else begin
            unique case (st)
                SY_IDLE: begin
                    if (wr_req && wr_val && !run) begin
                        st  <= SY_ARM;
                        cnt <= CW'(SYNC_CYC - 1);
                    end else if (wr_req && !wr_val && run) begin
                        st <= SY_DRAIN;
                    end
                end
                SY_ARM: begin
                    if (cnt == '0) begin
                        run <= 1'b1;
                        st  <= SY_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SY_DRAIN: begin
                    if (drained) begin
                        run <= 1'b0;
                        st  <= SY_IDLE;
                    end
                end
                default: st <= SY_IDLE;
            endcase
        end
    end

    assign busy = (st != SY_IDLE);

    // peripheral off: changes are immediate, never pending
    assert_no_busy_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        !periph_en |=> !busy);

    // enabling under a live peripheral only lands at the end of a handshake
    assert_enable_via_handshake_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(run) && $past(periph_en)) |-> $past(busy));

    // disabling under a live peripheral waits for the queue to drain
    assert_disable_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(run) && $past(periph_en)) |-> $past(drained));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              tick,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              load,
    output logic              busy,
    output logic              txd
);
    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

    logic [FRAME_MAX-1:0] sh;
    logic [LW-1:0]        left;
    logic [TW-1:0]        tcnt;

    assign load = active && have_data && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
            tcnt <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sh   <= build_frame(data, cfg);
            left <= frame_len(cfg);
            tcnt <= '0;
            busy <= 1'b1;
        end else if (busy && tick) begin
            if (tcnt == TW'(OVS - 1)) begin
                tcnt <= '0;
                sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                left <= left - 1'b1;
                if (left == LW'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign txd = busy ? sh[0] : 1'b1;

    assert_start_bit_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // the line only changes at a bit boundary inside a frame
    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !($past(tick) && $past(tcnt) == TW'(OVS - 1)))
            |-> $stable(txd));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int SYNC_CYC = 3,
    parameter int REG_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              periph_en,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_in,
    output logic              dat_empty,
    input  logic              baud_tick,
    output logic              txd,
    output logic              sync_busy,
    output logic              tx_running
);
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] buf_q;
    logic              buf_vld;
    logic              run;
    logic              active;
    logic              load;
    logic              shift_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (reg_wr) begin
            cfg_q.par_en   <= reg_wdata[CTL_PAR];
            cfg_q.par_odd  <= reg_wdata[CTL_ODD];
            cfg_q.two_stop <= reg_wdata[CTL_STOP2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            buf_vld <= 1'b0;
        end else if (dat_wr && !buf_vld) begin
            buf_q   <= dat_in;
            buf_vld <= 1'b1;
        end else if (load) begin
            buf_vld <= 1'b0;
        end
    end

    sertx_sync #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .periph_en (periph_en),
        .wr_req    (reg_wr),
        .wr_val    (reg_wdata[CTL_EN]),
        .drained   (!shift_busy && !buf_vld),
        .run       (run),
        .busy      (sync_busy)
    );

    assign active = periph_en && run;

    sertx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .tick      (baud_tick),
        .have_data (buf_vld),
        .data      (buf_q),
        .cfg       (cfg_q),
        .load      (load),
        .busy      (shift_busy),
        .txd       (txd)
    );

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[CTL_EN]    = run;
        reg_rdata[CTL_PAR]   = cfg_q.par_en;
        reg_rdata[CTL_ODD]   = cfg_q.par_odd;
        reg_rdata[CTL_STOP2] = cfg_q.two_stop;
    end

    assign dat_empty  = !buf_vld;
    assign tx_running = active;

    assert_buf_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (buf_vld && !load) |=> (buf_vld && $stable(buf_q)));

    assert_no_frame_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_busy) |-> $past(active));

endmodule

// File: tb/tb_sertx_core.sv
module tb_sertx_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        periph_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dat_wr = 1'b0;
    logic [7:0]  dat_in = '0;
    logic        dat_empty;
    logic        baud_tick = 1'b1;
    logic        txd;
    logic        sync_busy;
    logic        tx_running;

    int tests = 0;
    int fails = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sertx_core dut (
        .clk(clk), .rst(rst), .periph_en(periph_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_wr(dat_wr), .dat_in(dat_in), .dat_empty(dat_empty),
        .baud_tick(baud_tick), .txd(txd),
        .sync_busy(sync_busy), .tx_running(tx_running)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_in = v;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    // expected frame, bit 0 first; c = {two_stop, odd, par_en}
    function automatic int exp_len(input logic [2:0] c);
        return 10 + int'(c[0]) + int'(c[2]);
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [2:0] c);
        logic [11:0] f;
        int idx;
        logic p;
        f = '0;
        f[0] = 1'b0;
        for (int k = 0; k < 8; k++) f[k+1] = d[k];
        idx = 9;
        if (c[0]) begin
            p = c[1];
            for (int k = 0; k < 8; k++) p = p ^ d[k];
            f[idx] = p;
            idx++;
        end
        f[idx] = 1'b1;
        if (c[2]) f[idx+1] = 1'b1;
        return f;
    endfunction

    task automatic rx(input int n, output logic [11:0] bits, output longint t0);
        int guard;
        guard = 0;
        bits = '0;
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 5000, "R5 start bit seen", guard, 0);
        t0 = cyc;
        repeat (8) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            bits[k] = txd;
            if (k < n - 1) repeat (16) @(negedge clk);
        end
    endtask

    task automatic watch_idle(input int ncyc, input string req);
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
        end
        chk(ok, req, 0, 1);
    endtask

    function automatic logic [11:0] msk(input int n);
        return 12'((1 << n) - 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] b1, b2;
        longint t1, t2;
        logic [2:0] c;
        logic [7:0] d1, d2;
        int n;
        void'($urandom(32'h5EED));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd", txd, 1);
        chk(reg_rdata === 16'h0, "R1 rdata", reg_rdata, 0);
        chk(sync_busy === 1'b0, "R1 busy", sync_busy, 0);
        chk(dat_empty === 1'b1, "R1 empty", dat_empty, 1);

        // R2 reserved bits; R3 immediate while peripheral off
        wr_ctrl(16'hFFFF);
        chk(reg_rdata === 16'h000F, "R2 reserved read zero", reg_rdata, 16'h000F);
        chk(sync_busy === 1'b0, "R3 no busy when off", sync_busy, 0);
        wr_ctrl(16'h0000);
        chk(reg_rdata === 16'h0000, "R2 fields clear", reg_rdata, 0);
        wr_ctrl(16'h0001);
        chk(reg_rdata[0] === 1'b1, "R3 immediate enable", reg_rdata[0], 1);
        begin
            bit ok;
            ok = !sync_busy;
            repeat (3) begin @(negedge clk); if (sync_busy) ok = 1'b0; end
            chk(ok, "R3 busy stays low", 0, 0);
        end

        // peripheral on: quick disable with nothing queued
        periph_en = 1'b1;
        wr_ctrl(16'h0000);
        chk(sync_busy === 1'b1 && reg_rdata[0] === 1'b1, "R8 pending disable", {sync_busy, reg_rdata[0]}, 2'b11);
        @(negedge clk);
        chk(sync_busy === 1'b0 && reg_rdata[0] === 1'b0, "R8 disable done", {sync_busy, reg_rdata[0]}, 2'b00);

        // R4 handshake timing
        wr_ctrl(16'h0001);
        for (int k = 0; k < 3; k++) begin
            chk(sync_busy === 1'b1 && reg_rdata[0] === 1'b0, "R4 busy window", {sync_busy, reg_rdata[0]}, 2'b10);
            @(negedge clk);
        end
        chk(sync_busy === 1'b0 && reg_rdata[0] === 1'b1, "R4 enable landed", {sync_busy, reg_rdata[0]}, 2'b01);

        // R11 write during busy ignored
        wr_ctrl(16'h0000);
        repeat (2) @(negedge clk);
        wr_ctrl(16'h0001);
        wr_ctrl(16'h0000);
        @(negedge clk);
        chk(reg_rdata[0] === 1'b1 && sync_busy === 1'b0, "R11 write while busy ignored", {sync_busy, reg_rdata[0]}, 2'b01);

        // R10 / R9 buffered byte waits while disabled
        wr_ctrl(16'h0000);
        repeat (2) @(negedge clk);
        chk(reg_rdata[0] === 1'b0, "R10 disabled", reg_rdata[0], 0);
        wr_dat(8'hA5);
        chk(dat_empty === 1'b0, "R9 empty low after write", dat_empty, 0);
        wr_dat(8'h3C);
        watch_idle(40, "R10 no frame while disabled");
        chk(dat_empty === 1'b0, "R10 byte still held", dat_empty, 0);
        wr_ctrl(16'h0001);
        rx(10, b1, t1);
        chk((b1 & msk(10)) === (exp_frame(8'hA5, 3'b000) & msk(10)), "R9 first byte kept", b1, exp_frame(8'hA5, 3'b000));
        watch_idle(40, "R9 dropped byte not sent");
        chk(dat_empty === 1'b1, "R9 empty after load", dat_empty, 1);

        // R8 deferred disable with frame in flight and buffer full
        fork
            rx(10, b1, t1);
            begin
                wr_dat(8'h11);
                while (!dat_empty) @(negedge clk);
                wr_dat(8'h22);
                wr_ctrl(16'h0000);
                chk(sync_busy === 1'b1 && reg_rdata[0] === 1'b1, "R8 busy while draining", {sync_busy, reg_rdata[0]}, 2'b11);
            end
        join
        rx(10, b2, t2);
        chk((b1 & msk(10)) === (exp_frame(8'h11, 3'b000) & msk(10)), "R8 frame in flight", b1, exp_frame(8'h11, 3'b000));
        chk((b2 & msk(10)) === (exp_frame(8'h22, 3'b000) & msk(10)), "R8 buffered frame", b2, exp_frame(8'h22, 3'b000));
        repeat (20) @(negedge clk);
        chk(sync_busy === 1'b0 && reg_rdata[0] === 1'b0, "R8 disabled after drain", {sync_busy, reg_rdata[0]}, 2'b00);
        wr_dat(8'h33);
        watch_idle(40, "R8 no frame after disable");

        // re-enable (0x33 waits in buffer and goes first)
        wr_ctrl(16'h0001);
        rx(10, b1, t1);
        chk((b1 & msk(10)) === (exp_frame(8'h33, 3'b000) & msk(10)), "R10 held byte sent on enable", b1, exp_frame(8'h33, 3'b000));
        repeat (20) @(negedge clk);

        // R5 R6 R7 random frames, back to back
        for (int i = 0; i < 20; i++) begin
            c  = 3'($urandom);
            if (i == 0) c = 3'b001;
            if (i == 1) c = 3'b011;
            if (i == 2) c = 3'b100;
            if (i == 3) c = 3'b111;
            d1 = 8'($urandom);
            d2 = 8'($urandom);
            if (i == 4) begin d1 = 8'h00; d2 = 8'hFF; end
            n  = exp_len(c);
            wr_ctrl({12'h000, c, 1'b1});
            fork
                rx(n, b1, t1);
                begin
                    wr_dat(d1);
                    while (!dat_empty) @(negedge clk);
                    wr_dat(d2);
                end
            join
            rx(n, b2, t2);
            chk((b1 & msk(n)) === (exp_frame(d1, c) & msk(n)), "R5/R6 frame one", b1, exp_frame(d1, c));
            chk((b2 & msk(n)) === (exp_frame(d2, c) & msk(n)), "R6 frame two", b2, exp_frame(d2, c));
            chk((t2 - t1) == longint'(16 * n + 1), "R7 frame spacing", t2 - t1, 16 * n + 1);
            repeat (24) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule